// File: doc/BRIEF.md
# Command Doorbell Mailbox with Sticky Status

This block is the software-facing command mailbox of a sideband link controller. Software fills a bank of transmit dwords over a simple register bus, then writes dword 0 with its go bit set. That write is the doorbell: it hands the contents of all the dwords to a link engine in a single-cycle start pulse. The go bit reads back as 1 for as long as the command is outstanding. When the engine returns a done pulse, the go bit clears and the block records the outcome in a write-one-to-clear interrupt status register. Any response data the engine returns overwrites dword 1.

Software therefore loads dwords 1 to 3 first and dword 0 last. It polls the go bit or waits for the level interrupt, reads the status register, and writes the value it read back to acknowledge it. The sequencing is a three-state machine. IDLE moves to ISSUE on a doorbell write. ISSUE always moves to WAIT on the next cycle and drives the start pulse. WAIT moves back to IDLE when the engine signals done. A doorbell write that arrives while a command is outstanding is refused and flagged.

Top module: `cmd_doorbell`

## Requirements
- R1: After reset, all dwords and the status register read 0, irq is 0, and eng_start is 0.
- R2: Dwords 0 to 3 are read and written at byte offsets 0x00, 0x04, 0x08 and 0x0C. The status register is at 0x10. Reads of any other offset (0x14 to 0x1C) return 0.
- R3: A write to dword 0 with bit 3 (go) set while idle raises eng_start for exactly one cycle, the cycle after the write. During that cycle eng_cmd carries dword N in bits [32N+31:32N], and word 0 has go set. A dword 0 write with go clear is stored but launches nothing.
- R4: Bit 3 of dword 0 reads 1 from the cycle after a launch until the cycle after the engine's done pulse, and reads 0 after that.
- R5: On completion, status bit 28 is set. Engine status bits 0 (bus error), 1 (wait timeout), 2 (CRC error), 4 (no response), 5 (fatal) and 6 (non-fatal) are ORed into the same positions. All other engine status bits are dropped.
- R6: On completion with eng_resp_vld high and engine status bit 4 clear, dword 1 takes eng_resp. Otherwise dword 1 keeps its value.
- R7: A write to the status register clears exactly the bits written as 1. A status bit set by an event in the same cycle as the clear stays set.
- R8: A write to dword 0 while go reads 1 is ignored (no change to dword 0, no new eng_start) and sets sticky status bit 20.
- R9: irq is 1 exactly when the status register is nonzero.
- R10: Stored dword 0 keeps target bits [7:4], address-high bits [11:8] and address-low bits [23:18] as written, and forces bits [17:16] to 0.
- R11: An eng_done pulse while no command is outstanding changes neither status nor dword 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt, status nonzero |
| eng_start | output | 1 | One-cycle command launch to engine |
| eng_cmd | output | NUM_DW*32 | All transmit dwords, dword 0 lowest |
| eng_done | input | 1 | Engine completion pulse |
| eng_status | input | 32 | Engine outcome bits, valid with eng_done |
| eng_resp_vld | input | 1 | Response data present with eng_done |
| eng_resp | input | 32 | Response data |

## Verification
The main launch-and-complete path is swept 32 times. Each pass uses a different target and address field, and drives an engine status with exactly one of the 32 bits set. This separates the status bits that are kept from those that are dropped, and it tests the no-response gating of the dword 1 update with the response-valid flag both high and low. The engine delay varies across passes, which shows that the go bit tracks the outstanding command and not a fixed latency. Separate patterns cover a doorbell write with go clear, a refused doorbell while busy, a stray done while idle, a partial acknowledge, and a clear that lands in the same cycle as a completion.

// File: rtl/cmd_doorbell_pkg.sv
package cmd_doorbell_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } db_state_e;

    localparam int GO_BIT        = 3;
    localparam int STS_BUS_ERR   = 0;
    localparam int STS_WAIT_TO   = 1;
    localparam int STS_CRC_ERR   = 2;
    localparam int STS_NO_RESP   = 4;
    localparam int STS_FATAL     = 5;
    localparam int STS_NONFATAL  = 6;
    localparam int STS_OVERRUN   = 20;
    localparam int STS_CMD_DONE  = 28;

    localparam logic [31:0] ENG_ERR_MASK =
        (32'd1 << STS_BUS_ERR) | (32'd1 << STS_WAIT_TO) | (32'd1 << STS_CRC_ERR) |
        (32'd1 << STS_NO_RESP) | (32'd1 << STS_FATAL)   | (32'd1 << STS_NONFATAL);

    // address-low alignment bits that are held at zero in dword 0
    localparam logic [31:0] DW0_ZERO_MASK = 32'h0003_0000;

endpackage

// File: rtl/db_fsm.sv
module db_fsm
    import cmd_doorbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic eng_done,
    output logic busy,
    output logic eng_start,
    output logic done_evt
);

    db_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (eng_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b1;
        eng_start = 1'b0;
        done_evt  = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_ISSUE: eng_start = 1'b1;
            ST_WAIT:  done_evt = eng_done;
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/db_dword_bank.sv
module db_dword_bank
    import cmd_doorbell_pkg::*;
#(
    parameter int NUM_DW   = 4,
    parameter int RESP_IDX = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_DW-1:0]      we,
    input  logic [31:0]            wval,
    input  logic                   resp_load,
    input  logic [31:0]            resp,
    output logic [NUM_DW*32-1:0]   dw_flat
);

    for (genvar i = 0; i < NUM_DW; i++) begin : g_dw
        logic [31:0] q;
        if (i == 0) begin : g_cmd
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we[i]) begin
                    q <= wval & ~DW0_ZERO_MASK & ~(32'd1 << GO_BIT);
                end
            end
        end else if (i == RESP_IDX) begin : g_resp
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (resp_load) begin
                    q <= resp;
                end else if (we[i]) begin
                    q <= wval;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we[i]) begin
                    q <= wval;
                end
            end
        end
        assign dw_flat[i*32 +: 32] = q;
    end

endmodule

// File: rtl/db_status.sv
module db_status (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] set_vec,
    input  logic [31:0] clr_vec,
    output logic [31:0] sts
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/cmd_doorbell.sv
module cmd_doorbell
    import cmd_doorbell_pkg::*;
#(
    parameter int NUM_DW = 4,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output logic                  irq,
    output logic                  eng_start,
    output logic [NUM_DW*32-1:0]  eng_cmd,
    input  logic                  eng_done,
    input  logic [31:0]           eng_status,
    input  logic                  eng_resp_vld,
    input  logic [31:0]           eng_resp
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    idx;
    logic                sel_sts;
    logic [NUM_DW-1:0]   dw_sel;
    logic [NUM_DW-1:0]   dw_we;
    logic                dw0_wr, overrun, launch;
    logic                busy, done_evt, resp_load;
    logic [31:0]         sts_q, set_vec, clr_vec;
    logic [NUM_DW*32-1:0] dw_flat;
    logic [31:0]         go_word;

    assign idx     = addr[ADDR_W-1:2];
    assign sel_sts = (int'(idx) == NUM_DW);

    for (genvar i = 0; i < NUM_DW; i++) begin : g_dec
        assign dw_sel[i] = (int'(idx) == i);
    end

    assign dw0_wr  = wr_en && dw_sel[0];
    assign overrun = dw0_wr && busy;
    assign launch  = dw0_wr && !busy && wdata[GO_BIT];
    assign dw_we   = wr_en ? (dw_sel & ~(NUM_DW'(busy))) : '0;

    db_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .eng_done  (eng_done),
        .busy      (busy),
        .eng_start (eng_start),
        .done_evt  (done_evt)
    );

    assign resp_load = done_evt && eng_resp_vld && !eng_status[STS_NO_RESP];

    db_dword_bank #(
        .NUM_DW   (NUM_DW),
        .RESP_IDX (1)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (dw_we),
        .wval      (wdata),
        .resp_load (resp_load),
        .resp      (eng_resp),
        .dw_flat   (dw_flat)
    );

    always_comb begin
        set_vec = '0;
        if (done_evt) begin
            set_vec = (eng_status & ENG_ERR_MASK) | (32'd1 << STS_CMD_DONE);
        end
        if (overrun) begin
            set_vec[STS_OVERRUN] = 1'b1;
        end
        clr_vec = (wr_en && sel_sts) ? wdata : '0;
    end

    db_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .sts     (sts_q)
    );

    assign go_word = {28'd0, busy, 3'd0};
    assign irq     = |sts_q;

    always_comb begin
        eng_cmd        = dw_flat;
        eng_cmd[31:0]  = dw_flat[31:0] | go_word;
    end

    always_comb begin
        rdata = '0;
        if (sel_sts) begin
            rdata = sts_q;
        end else begin
            for (int i = 0; i < NUM_DW; i++) begin
                if (dw_sel[i]) begin
                    rdata = eng_cmd[i*32 +: 32];
                end
            end
        end
    end

endmodule

// File: rtl/db_checker.sv
module db_checker #(
    parameter int NUM_DW = 4,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic              eng_start,
    input logic              eng_done,
    input logic              busy,
    input logic [31:0]       sts_q
);

    localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(NUM_DW * 4);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R4
    issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> busy);

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy && !eng_start) |=> sts_q[28]);

    // R8
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && busy) |=> (sts_q[20] && !eng_start));

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && addr == STS_ADDR));

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !busy && !wr_en) |=> $stable(sts_q));

endmodule

bind cmd_doorbell db_checker #(
    .NUM_DW (NUM_DW),
    .ADDR_W (ADDR_W)
) i_db_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .irq       (irq),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .busy      (busy),
    .sts_q     (sts_q)
);

// File: tb/test_cmd_doorbell.sv
`timescale 1ns/1ps
module test_cmd_doorbell;

    localparam int NUM_DW = 4;
    localparam int ADDR_W = 5;
    localparam logic [31:0] KEEP = 32'h1000_0077;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [31:0]          wdata = '0;
    logic [31:0]          rdata;
    logic                 irq;
    logic                 eng_start;
    logic [NUM_DW*32-1:0] eng_cmd;
    logic                 eng_done = 1'b0;
    logic [31:0]          eng_status = '0;
    logic                 eng_resp_vld = 1'b0;
    logic [31:0]          eng_resp = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cmd_doorbell #(.NUM_DW(NUM_DW), .ADDR_W(ADDR_W)) i_cmd_doorbell (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .eng_start(eng_start), .eng_cmd(eng_cmd),
        .eng_done(eng_done), .eng_status(eng_status),
        .eng_resp_vld(eng_resp_vld), .eng_resp(eng_resp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic pulse_done(input logic [31:0] st, input logic vld, input logic [31:0] rsp);
        @(negedge clk);
        eng_done = 1'b1; eng_status = st; eng_resp_vld = vld; eng_resp = rsp;
        @(negedge clk);
        eng_done = 1'b0; eng_status = '0; eng_resp_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, w0, exp0, dw1_exp, st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a <= 4; a++) begin
            rd(ADDR_W'(a * 4), v);
            check("R1 reset register", v, 32'd0);
        end
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 eng_start", {31'd0, eng_start}, 32'd0);

        // R2 offsets and unmapped reads
        wr(5'h04, 32'h1111_2222);
        wr(5'h08, 32'h3333_4444);
        wr(5'h0C, 32'h5555_6666);
        rd(5'h04, v); check("R2 dword1", v, 32'h1111_2222);
        rd(5'h08, v); check("R2 dword2", v, 32'h3333_4444);
        rd(5'h0C, v); check("R2 dword3", v, 32'h5555_6666);
        for (int a = 5; a < 8; a++) begin
            rd(ADDR_W'(a * 4), v);
            check("R2 unmapped", v, 32'd0);
        end

        // R3 R10 dword0 without go: stored, no launch
        wr(5'h00, 32'hFFFF_FFF7);
        check("R3 no start without go", {31'd0, eng_start}, 32'd0);
        rd(5'h00, v); check("R10 bits 17:16 forced zero", v, 32'hFFFC_FFF7);
        @(negedge clk);
        check("R3 still no start", {31'd0, eng_start}, 32'd0);

        // Main sweep: one engine status bit per pass
        for (int b = 0; b < 32; b++) begin
            logic vld;
            logic [31:0] rsp;
            vld = (b % 2) == 0;
            rsp = 32'hC0DE_0000 + 32'(b);
            wr(5'h04, 32'hA000_0000 + 32'(b));
            wr(5'h08, 32'hB000_0000 + 32'(b));
            wr(5'h0C, 32'hD000_0000 + 32'(b));
            w0 = (32'(b % 64) << 18) | 32'h0003_0000 | (32'((b + 3) % 16) << 8)
                 | (32'(b % 16) << 4) | 32'h8 | 32'(b % 8);
            exp0 = w0 & ~32'h0003_0000;
            wr(5'h00, w0);
            check("R3 start pulse", {31'd0, eng_start}, 32'd1);
            check("R3 R10 cmd word0", eng_cmd[31:0], exp0);
            check("R3 cmd word1", eng_cmd[63:32], 32'hA000_0000 + 32'(b));
            check("R3 cmd word3", eng_cmd[127:96], 32'hD000_0000 + 32'(b));
            rd(5'h00, v); check("R4 go set", v, exp0);
            @(negedge clk);
            check("R3 single cycle", {31'd0, eng_start}, 32'd0);
            for (int d = 0; d < b % 4; d++) @(negedge clk);
            rd(5'h00, v); check("R4 go held while waiting", 32'(v[3]), 32'd1);
            pulse_done(32'd1 << b, vld, rsp);
            rd(5'h00, v); check("R4 go cleared", v, exp0 & ~32'h8);
            st = ((32'd1 << b) & KEEP & ~32'h1000_0000) | 32'h1000_0000;
            rd(5'h10, v); check("R5 status capture", v, st);
            check("R9 irq set", {31'd0, irq}, 32'd1);
            dw1_exp = (vld && b != 4) ? rsp : 32'hA000_0000 + 32'(b);
            rd(5'h04, v); check("R6 response into dword1", v, dw1_exp);
            wr(5'h10, st);
            rd(5'h10, v); check("R7 clear by write back", v, 32'd0);
            check("R9 irq clear", {31'd0, irq}, 32'd0);
        end

        // R8 doorbell while busy
        wr(5'h04, 32'h0000_0001);
        wr(5'h00, 32'h0000_0018);
        wr(5'h00, 32'h0000_00F8);
        check("R8 no second start", {31'd0, eng_start}, 32'd0);
        rd(5'h00, v); check("R8 dword0 unchanged", v, 32'h0000_0018);
        rd(5'h10, v); check("R8 overrun flag", v, 32'h0010_0000);
        // R7 same-cycle clear and completion: set wins
        @(negedge clk);
        wr_en = 1'b1; addr = 5'h10; wdata = 32'h1010_0001;
        eng_done = 1'b1; eng_status = 32'h0000_0001; eng_resp_vld = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; eng_done = 1'b0; eng_status = '0;
        rd(5'h10, v); check("R7 set wins over clear", v, 32'h1000_0001);
        // R7 partial clear
        wr(5'h10, 32'h0000_0001);
        rd(5'h10, v); check("R7 partial clear", v, 32'h1000_0000);
        wr(5'h10, 32'h1000_0000);

        // R11 stray done while idle
        pulse_done(32'h0000_0077, 1'b1, 32'hDEAD_BEEF);
        rd(5'h10, v); check("R11 status untouched", v, 32'd0);
        rd(5'h04, v); check("R11 dword1 untouched", v, 32'h0000_0001);
        check("R11 irq low", {31'd0, irq}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule